// File: doc/BRIEF.md
# Scrubbed SECDED Word Memory

This block is a clocked model of a word-wide static memory in which every stored word carries seven check bits: enough to repair any single flipped bit and to flag any pair of flipped bits. The host side keeps the control set of an asynchronous SRAM: two chip selects of opposite polarity, a low-true write strobe, a low-true output enable, an address and a 32-bit data bus. The bus is split into an input word, an output word and an output-enable flag. Stored words are encoded on write and decoded on every read, so the host always receives repaired data. A flag goes high beside any read, or any scrub, that meets a word it cannot repair.

A background scrubber walks an internal pointer across the array. At each step it decodes one word, writes the repaired word back if that word held a single flip, and moves the pointer on. A word with two flips is left unchanged and the flag is pulsed. A parameter picks the role. A master paces itself from a timer derived from the clock frequency and the scrub rate, and it raises a busy output for the cycle in which it scrubs, so that a memory controller can insert a wait state. A slave never scrubs on its own: it scrubs once for each rising edge on its command input, and it holds off host accesses while its busy input is high. One master can therefore pace many slaves.

A test-only port XORs a mask into a stored codeword so that single and double errors can be planted.

Top module: `edac_sram`

## Requirements
- R1: A write is accepted at a clock edge when `ce1_n`=0, `ce2`=1, `we_n`=0 and no stall is in force. It stores `dq_in` at the word selected by the low log2(DEPTH) bits of `addr`. Higher address bits are ignored.
- R2: A read is accepted at a clock edge when `ce1_n`=0, `ce2`=1, `we_n`=1, `oe_n`=0 and no stall is in force. In the following cycle `dq_oe`=1 and `dq_out` holds the repaired data word.
- R3: `dq_oe` is 0 in every cycle that follows an edge with no accepted read: after reset, with `ce1_n`=1, with `ce2`=0, with `oe_n`=1, or during a write. `mbe` and `busy_o` are 0 after reset.
- R4: A read of a word with exactly one flipped codeword bit, including the overall parity bit, returns the original data with `mbe`=0.
- R5: A read of a word with two flipped codeword bits returns `mbe`=1 in the same cycle as `dq_oe`=1.
- R6: In master mode a scrub is requested every PERIOD = CLK_HZ/SCRUB_HZ cycles. `busy_o` is high for exactly the one cycle of each scrub, so an idle master shows one busy cycle per PERIOD.
- R7: A host access at an edge that ends a cycle with `busy_o`=1 (master), or at an edge where `busy_i`=1 (slave), is not performed. A stalled write leaves memory unchanged, and a stalled read gives `dq_oe`=0.
- R8: A scrub never starts at an edge where a host write is accepted. A pending scrub waits until the first edge without one.
- R9: A scrub decodes the word at the scrub pointer. If the word holds a single error, the scrub writes back the repaired codeword. The pointer then advances by one and wraps from DEPTH-1 to 0, starting at 0 after reset.
- R10: A scrub that finds two errors leaves the word unchanged and raises `mbe` for one cycle with `dq_oe`=0.
- R11: In slave mode no scrub happens without a rising edge on `scrub_cmd`. Each rising edge causes exactly one scrub, and `busy_o` stays 0.
- R12: The 39-bit codeword has overall parity at bit 0, Hamming check bits at positions 1, 2, 4, 8, 16 and 32, and data bits in ascending order in the remaining positions 3..38. When `inj_en`=1, `inj_mask` is XORed into the stored codeword at `inj_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce1_n | input | 1 | Chip select, low-true |
| ce2 | input | 1 | Chip select, high-true |
| we_n | input | 1 | Write strobe, low-true |
| oe_n | input | 1 | Output enable, low-true |
| addr | input | ADDR_W | Word address |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable (0 = high impedance) |
| busy_o | output | 1 | Scrub in progress (master only) |
| busy_i | input | 1 | External hold-off (slave only) |
| scrub_cmd | input | 1 | Scrub command, rising edge (slave only) |
| mbe | output | 1 | Uncorrectable word seen by a read or a scrub |
| inj_en | input | 1 | Test: apply an error mask |
| inj_addr | input | ADDR_W | Test: word to corrupt |
| inj_mask | input | 39 | Test: codeword bits to flip |

## Verification
Reads are issued against clean words, against words with one planted flip in a data position and in the parity position, and against words with two flips. This separates repair from plain storage, and separates a repairable word from a detected-only one. Scrub writeback is shown by planting a flip, letting a full pointer sweep pass and planting a second flip: a repaired word then reads clean, while a slave left without commands reads the same sequence as uncorrectable. Busy pacing is measured over an idle window, under a held write, and with writes and reads timed into the busy cycle or into a high `busy_i`, which shows apart pacing, deferral and hold-off.

// File: rtl/edac_pkg.sv
`timescale 1ns/1ps
package edac_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef enum logic {SCR_IDLE, SCR_RUN} scr_state_e;

    // Spread data over the non-power-of-two positions, fill Hamming bits, then overall parity at bit 0.
    function automatic logic [CW_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        int k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < HAM_W; b++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (p[b] && ((p & (p - 1)) != 0)) par = par ^ cw[p];
            end
            cw[1 << b] = par;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] secded_data(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/secded_check.sv
`timescale 1ns/1ps
module secded_check
    import edac_pkg::*;
(
    input  logic [CW_W-1:0]   cw_in,
    output logic [CW_W-1:0]   cw_fixed,
    output logic [DATA_W-1:0] data_fixed,
    output logic              err_single,
    output logic              err_double
);

    logic [HAM_W-1:0] syn;
    logic             parity_bad;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw_in[p]) syn = syn ^ HAM_W'(p);
        end
        parity_bad = ^cw_in;

        cw_fixed   = cw_in;
        err_single = 1'b0;
        err_double = 1'b0;
        if (parity_bad) begin
            // odd flip count: syndrome names the bit, 0 means the parity bit itself
            if (syn < HAM_W'(CW_W)) begin
                err_single    = 1'b1;
                cw_fixed[syn] = ~cw_in[syn];
            end else begin
                err_double = 1'b1;
            end
        end else if (syn != '0) begin
            err_double = 1'b1;
        end
        data_fixed = secded_data(cw_fixed);
    end

endmodule

// File: rtl/edac_store.sv
`timescale 1ns/1ps
module edac_store
    import edac_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CW_W-1:0]  wr_cw,
    input  logic             flip_en,
    input  logic [IDX_W-1:0] flip_idx,
    input  logic [CW_W-1:0]  flip_mask,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CW_W-1:0]  rd_cw
);

    logic [CW_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)   cells_q[wr_idx]   <= wr_cw;
        if (flip_en) cells_q[flip_idx] <= cells_q[flip_idx] ^ flip_mask;
    end

    assign rd_cw = cells_q[rd_idx];

endmodule

// File: rtl/scrub_pacer.sv
`timescale 1ns/1ps
module scrub_pacer #(
    parameter bit MASTER = 1'b1,
    parameter int PERIOD = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scrub_cmd,
    output logic req
);

    localparam int              CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cmd;
    } pace_t;

    pace_t pace_q, pace_d;
    logic  tick, cmd_rise;

    always_comb begin
        pace_d     = pace_q;
        tick       = (pace_q.cnt == LAST);
        pace_d.cnt = tick ? '0 : pace_q.cnt + CNT_W'(1);
        pace_d.cmd = scrub_cmd;
        cmd_rise   = scrub_cmd && !pace_q.cmd;
        req        = MASTER ? tick : cmd_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pace_q <= '0;
        else        pace_q <= pace_d;
    end

    // R6 / R11: a request is never raised on two edges in a row
    a_r6_req_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

endmodule

// File: rtl/edac_sram.sv
`timescale 1ns/1ps
module edac_sram
    import edac_pkg::*;
#(
    parameter bit MASTER   = 1'b1,
    parameter int ADDR_W   = 19,
    parameter int DEPTH    = 1024,
    parameter int CLK_HZ   = 50_000_000,
    parameter int SCRUB_HZ = 156_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy_o,
    input  logic              busy_i,
    input  logic              scrub_cmd,
    output logic              mbe,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [CW_W-1:0]   inj_mask
);

    localparam int               IDX_W    = $clog2(DEPTH);
    localparam int               PERIOD   = CLK_HZ / SCRUB_HZ;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        scr_state_e        st;
        logic              pend;
        logic [IDX_W-1:0]  ptr;
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic              mbe;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              host_wr, host_rd, stall, wr_go, rd_go;
    logic              scrubbing, scrub_req;
    logic [IDX_W-1:0]  rd_idx, st_wr_idx;
    logic              st_wr_en;
    logic [CW_W-1:0]   st_wr_cw, rd_cw, fix_cw;
    logic [DATA_W-1:0] fix_data;
    logic              err_single, err_double;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^{addr[ADDR_W-1:IDX_W], inj_addr[ADDR_W-1:IDX_W]};

    // host decode and hold-off
    always_comb begin
        scrubbing = (ctl_q.st == SCR_RUN);
        host_wr   = !ce1_n && ce2 && !we_n;
        host_rd   = !ce1_n && ce2 && we_n && !oe_n;
        stall     = scrubbing || (!MASTER && busy_i);
        wr_go     = host_wr && !stall;
        rd_go     = host_rd && !stall;
        rd_idx    = scrubbing ? ctl_q.ptr : addr[IDX_W-1:0];
    end

    scrub_pacer #(.MASTER(MASTER), .PERIOD(PERIOD)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .scrub_cmd (scrub_cmd),
        .req       (scrub_req)
    );

    edac_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .wr_en     (st_wr_en),
        .wr_idx    (st_wr_idx),
        .wr_cw     (st_wr_cw),
        .flip_en   (inj_en),
        .flip_idx  (inj_addr[IDX_W-1:0]),
        .flip_mask (inj_mask),
        .rd_idx    (rd_idx),
        .rd_cw     (rd_cw)
    );

    secded_check u_check (
        .cw_in      (rd_cw),
        .cw_fixed   (fix_cw),
        .data_fixed (fix_data),
        .err_single (err_single),
        .err_double (err_double)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.oe   = 1'b0;
        ctl_d.mbe  = 1'b0;
        ctl_d.pend = ctl_q.pend | scrub_req;
        st_wr_en   = 1'b0;
        st_wr_idx  = addr[IDX_W-1:0];
        st_wr_cw   = secded_encode(dq_in);
        if (scrubbing) begin
            ctl_d.st  = SCR_IDLE;
            ctl_d.ptr = (ctl_q.ptr == LAST_IDX) ? '0 : ctl_q.ptr + IDX_W'(1);
            ctl_d.mbe = err_double;
            if (err_single) begin
                st_wr_en  = 1'b1;
                st_wr_idx = ctl_q.ptr;
                st_wr_cw  = fix_cw;
            end
        end else begin
            if (wr_go) st_wr_en = 1'b1;
            if (rd_go) begin
                ctl_d.oe   = 1'b1;
                ctl_d.dout = fix_data;
                ctl_d.mbe  = err_double;
            end
            if (ctl_d.pend && !wr_go) begin
                ctl_d.st   = SCR_RUN;
                ctl_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dq_out = ctl_q.dout;
    assign dq_oe  = ctl_q.oe;
    assign mbe    = ctl_q.mbe;
    assign busy_o = MASTER ? scrubbing : 1'b0;

    // R3: a write cycle never turns the bus drivers on
    a_r3_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> !dq_oe);

    // R7: nothing is read out of a stalled cycle
    a_r7_no_read_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !dq_oe);

    // R8: an accepted write keeps the scrubber idle
    a_r8_write_defers_scrub: assert property (@(posedge clk) disable iff (!rst_n)
        (!scrubbing && wr_go) |=> !scrubbing);

    // R9: pointer steps by one per scrub and wraps at the top
    a_r9_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        scrubbing |=> (ctl_q.ptr == (($past(ctl_q.ptr) == LAST_IDX) ? IDX_W'(0)
                                     : $past(ctl_q.ptr) + IDX_W'(1))));

endmodule

// File: tb/edac_sram_test.sv
`timescale 1ns/1ps
module edac_sram_test;

    localparam int AW  = 19;
    localparam int DEP = 16;
    localparam int PER = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // master side
    logic m_ce1_n = 1, m_ce2 = 1, m_we_n = 1, m_oe_n = 1;
    logic [AW-1:0] m_addr = '0, m_inj_addr = '0;
    logic [31:0] m_din = '0, m_dout;
    logic m_oe, m_busy, m_mbe, m_inj_en = 0;
    logic [38:0] m_inj_mask = '0;
    // slave side
    logic s_ce1_n = 1, s_ce2 = 1, s_we_n = 1, s_oe_n = 1;
    logic [AW-1:0] s_addr = '0, s_inj_addr = '0;
    logic [31:0] s_din = '0, s_dout;
    logic s_oe, s_busy, s_mbe, s_inj_en = 0, s_busy_i = 0, s_cmd = 0;
    logic [38:0] s_inj_mask = '0;

    edac_sram #(.MASTER(1'b1), .ADDR_W(AW), .DEPTH(DEP), .CLK_HZ(50_000_000), .SCRUB_HZ(2_500_000)) uut (
        .clk(clk), .rst_n(rst_n), .ce1_n(m_ce1_n), .ce2(m_ce2), .we_n(m_we_n), .oe_n(m_oe_n),
        .addr(m_addr), .dq_in(m_din), .dq_out(m_dout), .dq_oe(m_oe), .busy_o(m_busy),
        .busy_i(1'b0), .scrub_cmd(1'b0), .mbe(m_mbe),
        .inj_en(m_inj_en), .inj_addr(m_inj_addr), .inj_mask(m_inj_mask));

    edac_sram #(.MASTER(1'b0), .ADDR_W(AW), .DEPTH(DEP), .CLK_HZ(50_000_000), .SCRUB_HZ(2_500_000)) uut_slave (
        .clk(clk), .rst_n(rst_n), .ce1_n(s_ce1_n), .ce2(s_ce2), .we_n(s_we_n), .oe_n(s_oe_n),
        .addr(s_addr), .dq_in(s_din), .dq_out(s_dout), .dq_oe(s_oe), .busy_o(s_busy),
        .busy_i(s_busy_i), .scrub_cmd(s_cmd), .mbe(s_mbe),
        .inj_en(s_inj_en), .inj_addr(s_inj_addr), .inj_mask(s_inj_mask));

    logic [31:0] m_model [DEP];
    logic [31:0] s_model [DEP];

    // scoreboard of expected master reads
    logic [31:0] q_data [$];
    logic        q_mbe  [$];
    string       q_tag  [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i, input logic [31:0] seed);
        return seed ^ (32'h0102_0408 * (i + 1)) ^ {i[7:0], 24'h0};
    endfunction

    // monitor: pops one expected item per driven read word
    always @(negedge clk) begin
        if (rst_n && m_oe) begin
            if (q_data.size() == 0) begin
                check("R2 unexpected bus drive", 32'd1, 32'd0);
            end else begin
                logic [31:0] ed;
                logic        em;
                string       tg;
                ed = q_data.pop_front();
                em = q_mbe.pop_front();
                tg = q_tag.pop_front();
                check({tg, " mbe"}, {31'd0, m_mbe}, {31'd0, em});
                if (!em) check({tg, " data"}, m_dout, ed);
            end
        end
    end

    task automatic m_write(input int a, input logic [31:0] d);
        @(negedge clk);
        m_ce1_n = 0; m_ce2 = 1; m_we_n = 0; m_oe_n = 1; m_addr = AW'(a); m_din = d;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        m_we_n = 1; m_ce1_n = 1;
        m_model[a] = d;
        check("R3 oe low after write", {31'd0, m_oe}, 32'd0);
    endtask

    task automatic m_read(input int a, input logic em, input string tag);
        q_data.push_back(m_model[a]);
        q_mbe.push_back(em);
        q_tag.push_back(tag);
        @(negedge clk);
        m_ce1_n = 0; m_ce2 = 1; m_we_n = 1; m_oe_n = 0; m_addr = AW'(a);
        while (m_busy) @(negedge clk);
        @(negedge clk);
        m_oe_n = 1; m_ce1_n = 1;
    endtask

    task automatic m_inject(input int a, input logic [38:0] mask);
        @(negedge clk);
        while (m_busy) @(negedge clk);
        m_inj_en = 1; m_inj_addr = AW'(a); m_inj_mask = mask;
        @(negedge clk);
        m_inj_en = 0;
    endtask

    task automatic s_write(input int a, input logic [31:0] d);
        @(negedge clk);
        s_ce1_n = 0; s_ce2 = 1; s_we_n = 0; s_oe_n = 1; s_addr = AW'(a); s_din = d;
        @(negedge clk);
        s_we_n = 1; s_ce1_n = 1;
        if (!s_busy_i) s_model[a] = d;
    endtask

    task automatic s_read(input int a, output logic [31:0] d, output logic e, output logic v);
        @(negedge clk);
        s_ce1_n = 0; s_ce2 = 1; s_we_n = 1; s_oe_n = 0; s_addr = AW'(a);
        @(negedge clk);
        d = s_dout; e = s_mbe; v = s_oe;
        s_oe_n = 1; s_ce1_n = 1;
    endtask

    task automatic s_inject(input int a, input logic [38:0] mask);
        @(negedge clk);
        s_inj_en = 1; s_inj_addr = AW'(a); s_inj_mask = mask;
        @(negedge clk);
        s_inj_en = 0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        re, rv;
        int          cnt;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R3: reset state
        check("R3 reset oe", {31'd0, m_oe}, 32'd0);
        check("R3 reset mbe", {31'd0, m_mbe}, 32'd0);
        check("R3 reset busy", {31'd0, m_busy}, 32'd0);

        // R1 / R2: fill and read back; upper address bits are ignored
        for (int i = 0; i < DEP; i++) m_write(i, pat(i, 32'hC3A5_0F1E));
        for (int i = 0; i < DEP; i++) s_write(i, pat(i, 32'h5E11_AB07));
        for (int i = 0; i < DEP; i++) m_read(i, 1'b0, "R1 R2 readback");
        m_write(DEP + 9, 32'hDEAD_BEEF);
        m_model[9] = 32'hDEAD_BEEF;
        m_read(9, 1'b0, "R1 alias high addr");

        // R3: deselected and output-disabled cycles leave the bus off
        @(negedge clk);
        m_ce1_n = 0; m_ce2 = 0; m_we_n = 1; m_oe_n = 0;
        @(negedge clk);
        check("R3 ce2 low", {31'd0, m_oe}, 32'd0);
        m_ce2 = 1; m_oe_n = 1;
        @(negedge clk);
        check("R3 oe_n high", {31'd0, m_oe}, 32'd0);
        m_ce1_n = 1;

        // R4 / R12: single flips in a data position and in the parity bit
        m_inject(3, 39'h1 << 7);
        m_read(3, 1'b0, "R4 R12 data-bit flip");
        m_inject(4, 39'h1);
        m_read(4, 1'b0, "R4 R12 parity-bit flip");

        // R5: double flip is flagged on read
        m_inject(5, (39'h1 << 2) | (39'h1 << 30));
        m_read(5, 1'b1, "R5 double flip");

        // R9: scrub repairs a single flip, so a later second flip is still correctable
        m_inject(6, 39'h1 << 11);
        repeat (2 * DEP * PER) @(negedge clk);
        m_inject(6, 39'h1 << 25);
        m_read(6, 1'b0, "R9 writeback");

        // R10: one scrub mbe pulse per sweep, word left as it was
        cnt = 0;
        repeat (DEP * PER) begin
            @(negedge clk);
            if (m_mbe && !m_oe) cnt++;
        end
        check("R10 scrub mbe pulses", cnt, 1);
        m_read(5, 1'b1, "R10 word left unchanged");
        m_write(5, pat(5, 32'h0BAD_F00D));

        // R6: idle pacing
        cnt = 0;
        repeat (20 * PER) begin
            @(negedge clk);
            if (m_busy) cnt++;
        end
        check("R6 busy cycles", cnt, 20);

        // R7: write timed into the busy cycle is dropped
        do @(negedge clk); while (!m_busy);
        m_ce1_n = 0; m_ce2 = 1; m_we_n = 0; m_addr = AW'(7); m_din = 32'h1234_5678;
        @(negedge clk);
        m_we_n = 1; m_ce1_n = 1;
        m_read(7, 1'b0, "R7 stalled write dropped");

        // R8: a held write keeps the scrubber off
        @(negedge clk);
        while (m_busy) @(negedge clk);
        m_ce1_n = 0; m_ce2 = 1; m_we_n = 0; m_addr = AW'(8); m_din = 32'h8888_0001;
        cnt = 0;
        repeat (3 * PER) begin
            @(negedge clk);
            if (m_busy) cnt++;
        end
        m_we_n = 1; m_ce1_n = 1;
        m_model[8] = 32'h8888_0001;
        check("R8 no busy under write", cnt, 0);
        cnt = 0;
        repeat (2) begin
            @(negedge clk);
            if (m_busy) cnt++;
        end
        check("R8 deferred scrub runs", cnt, 1);
        m_read(8, 1'b0, "R8 held write stored");

        // R11: slave without commands never repairs, and never raises busy
        s_inject(2, 39'h1 << 9);
        cnt = 0;
        repeat (2 * DEP * PER) begin
            @(negedge clk);
            if (s_busy) cnt++;
        end
        check("R11 slave busy stays low", cnt, 0);
        s_inject(2, 39'h1 << 33);
        s_read(2, rd, re, rv);
        check("R11 no autonomous scrub", {31'd0, re}, 32'd1);
        s_write(2, s_model[2]);

        // R11 / R9: one command scrubs pointer 0
        s_inject(0, 39'h1 << 20);
        @(negedge clk); s_cmd = 1;
        @(negedge clk); s_cmd = 0;
        repeat (3) @(negedge clk);
        s_inject(0, 39'h1 << 36);
        s_read(0, rd, re, rv);
        check("R11 commanded scrub mbe", {31'd0, re}, 32'd0);
        check("R11 commanded scrub data", rd, s_model[0]);

        // R7: slave hold-off via busy_i
        s_busy_i = 1;
        s_write(4, 32'hFFFF_0000);
        s_read(4, rd, re, rv);
        check("R7 slave read held off", {31'd0, rv}, 32'd0);
        s_busy_i = 0;
        s_read(4, rd, re, rv);
        check("R7 slave write dropped", rd, s_model[4]);
        check("R2 slave read drives", {31'd0, rv}, 32'd1);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", q_data.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule